// File: doc/BRIEF.md
# Parallel Flash Bus Operation Decoder

This block sits at the pin side of a parallel NOR-style flash device. On every clock it registers the active-low chip enable, output enable and write enable, the reset pin, a digital flag that stands for a high voltage on the reset pin, the width select, the address bus and the incoming data bus. From that registered snapshot it names the bus operation in a one-hot code and drives the data outputs with their per-bit output enables. It also hands each bus write to a command register as a single-cycle strobe with the captured address and data.

A small register array, loaded with a fixed computed pattern whenever the reset pin is low, stands in for the memory cells. The device comes out of reset in read-array mode, so plain reads return array words without any command. A bus write whose low data byte is not `F0` (hex) takes the device out of that mode, and reads then return the last command word. A later write with low byte `F0` restores read-array mode. With width select low the device is eight bits wide. Data pin 15 then serves as the lowest byte-address bit and picks a half of the selected word.

Top module: `pflash_bus_front`

## Requirements
- R1: While `rst_pin_n` is low, `op` is 8'h10 (reset) and `dq_oe` is zero. `op` always has exactly one bit set, with the encoding bit0 read, bit1 write, bit2 standby, bit3 output disable, bit4 reset, bit5 sector protect, bit6 sector unprotect, bit7 temporary unprotect.
- R2: With reset high and the high-voltage flag low, `ce_n` high gives standby (`op` = 8'h04) and `dq_oe` = 0.
- R3: With reset high, `ce_n` low, `oe_n` low, `we_n` high and `word_sel` high, `dq_oe` is 16'hFFFF. In read-array mode `dq_out` equals array word `addr[3:0]`, which is loaded at reset with (i*257) XOR 16'h5AC3 (16 bits). Without the flag, `op` is 8'h01.
- R4: With `word_sel` low, a driven read sets `dq_oe` to 16'h00FF. `dq_out[7:0]` is bits 15:8 of the selected word when `dq_in[15]` is 1, or bits 7:0 when it is 0, and `dq_out[15:8]` is zero.
- R5: Without the flag, with `ce_n` low, the combination `oe_n` high with `we_n` high, or `oe_n` low with `we_n` low, gives output disable (`op` = 8'h08) with `dq_oe` = 0.
- R6: Without the flag, `ce_n` low, `oe_n` high and `we_n` low give write (`op` = 8'h02). `cmd_wr` pulses for exactly one cycle when `we_n` rises while `ce_n` is low, `oe_n` is high and reset is high, and at no other time. With the pulse, `cmd_addr` = {addr, 0} in word mode or {addr, dq_in[15]} in byte mode, and `cmd_data` = `dq_in` in word mode or {8'h00, dq_in[7:0]} in byte mode.
- R7: A strobed command with low byte other than 8'hF0 leaves read-array mode, and reads then return the last command word (full or halved as in R3/R4). A strobed command with low byte 8'hF0 returns to read-array mode.
- R8: With the flag set, `ce_n` low, `oe_n` high, `we_n` low, `addr[1]`=1 and `addr[0]`=0, `op` is 8'h20 when `addr[6]`=0 and 8'h40 when `addr[6]`=1. In both cases `dq_oe` = 0.
- R9: With the flag set, every other control and address state gives `op` = 8'h80, and reads and command strobes behave as without the flag.
- R10: `op`, `dq_out`, `dq_oe` and the command outputs follow the pins sampled at the previous rising clock edge. A pin change does not reach them before that edge. `dq_out` is zero whenever `dq_oe` is zero.
- R11: Taking `rst_pin_n` low returns the device to read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| rst_hv | input | 1 | Reset pin is at the high-voltage level |
| word_sel | input | 1 | 1 = 16-bit width, 0 = 8-bit width |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data pins as inputs; bit 15 is the byte-address bit in 8-bit width |
| dq_out | output | 16 | Data pins as outputs |
| dq_oe | output | 16 | Per-bit output enables for the data pins |
| op | output | 8 | One-hot bus operation |
| cmd_wr | output | 1 | One-cycle command write strobe |
| cmd_addr | output | ADDR_W+1 | Byte address of the command write |
| cmd_data | output | 16 | Data of the command write |

## Verification
The bench keeps the defaults, ADDR_W = 7 and MEM_WORDS = 16. With these values every array word and both halves of every word can be read in turn. Every combination of chip, output and write enable can also be crossed with the high-voltage flag and all eight values of the A6/A1/A0 decode bits. The command path is driven in both widths, with the strobe both allowed and blocked, and through leaving and re-entering read-array mode by command and by reset.

// File: rtl/pflash_bus_front.sv
`timescale 1ns/1ps
module pflash_bus_front #(
  parameter int ADDR_W    = 7,
  parameter int MEM_WORDS = 16
) (
  input  logic              clk,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rst_pin_n,
  input  logic              rst_hv,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic [7:0]        op,
  output logic              cmd_wr,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int OP_RD = 0, OP_WR = 1, OP_SB = 2, OP_OD = 3,
                 OP_RS = 4, OP_PR = 5, OP_UP = 6, OP_TU = 7;
  localparam logic [7:0] RD_MODE_CODE = 8'hF0;

  logic ce_q, oe_q, we_q, we_d, rp_q, hv_q, word_q;
  logic [ADDR_W-1:0] a_q;
  logic [15:0] d_q;
  logic rd_mode;
  logic [15:0] last_cmd;
  logic [15:0] mem [MEM_WORDS];

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      ce_q <= 1'b1; oe_q <= 1'b1; we_q <= 1'b1; we_d <= 1'b1;
      rp_q <= 1'b0; hv_q <= 1'b0; word_q <= 1'b1;
      a_q <= '0; d_q <= '0;
    end else begin
      ce_q <= ce_n; oe_q <= oe_n; we_q <= we_n; we_d <= we_q;
      rp_q <= rst_pin_n; hv_q <= rst_hv; word_q <= word_sel;
      a_q <= addr; d_q <= dq_in;
    end

  always_comb begin
    op = '0;
    if (!rp_q) op[OP_RS] = 1'b1;
    else if (hv_q) begin
      if (!ce_q && oe_q && !we_q && a_q[1] && !a_q[0])
        op[a_q[6] ? OP_UP : OP_PR] = 1'b1;
      else
        op[OP_TU] = 1'b1;
    end
    else if (ce_q)          op[OP_SB] = 1'b1;
    else if (!oe_q && we_q) op[OP_RD] = 1'b1;
    else if (oe_q && !we_q) op[OP_WR] = 1'b1;
    else                    op[OP_OD] = 1'b1;
  end

  logic drive;
  logic [15:0] rd_word;
  logic [7:0]  rd_byte;

  assign drive   = rp_q & ~ce_q & ~oe_q & we_q;
  assign rd_word = rd_mode ? mem[a_q[IDX_W-1:0]] : last_cmd;
  assign rd_byte = d_q[15] ? rd_word[15:8] : rd_word[7:0];
  assign dq_oe   = !drive ? 16'h0000 : (word_q ? 16'hFFFF : 16'h00FF);
  assign dq_out  = !drive ? 16'h0000 : (word_q ? rd_word : {8'h00, rd_byte});

  assign cmd_wr   = rp_q & ~ce_q & oe_q & we_q & ~we_d;
  assign cmd_addr = {a_q, word_q ? 1'b0 : d_q[15]};
  assign cmd_data = word_q ? d_q : {8'h00, d_q[7:0]};

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      rd_mode  <= 1'b1;
      last_cmd <= '0;
      for (int i = 0; i < MEM_WORDS; i++)
        mem[i] <= 16'(i * 257) ^ 16'h5AC3;
    end else if (cmd_wr) begin
      last_cmd <= cmd_data;
      rd_mode  <= (cmd_data[7:0] == RD_MODE_CODE);
    end
endmodule

module pflash_bus_front_chk (
  input logic        clk,
  input logic        rst_pin_n,
  input logic        word_sel,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [15:0] dq_oe,
  input logic [15:0] dq_out,
  input logic [7:0]  op,
  input logic        rd_mode
);
  p_reset_hiz_r1: assert property (@(posedge clk)
    !rst_pin_n |-> (dq_oe == 16'h0000 && op == 8'h10));
  p_onehot_op_r1: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $countones(op) == 1);
  p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    op[2] |-> dq_oe == 16'h0000);
  p_byte_lanes_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(!word_sel) |-> dq_oe[15:8] == 8'h00);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    cmd_wr |=> !cmd_wr);
  p_f0_reenter_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (cmd_wr && cmd_data[7:0] == 8'hF0) |=> rd_mode);
  p_other_leave_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (cmd_wr && cmd_data[7:0] != 8'hF0) |=> !rd_mode);
  p_protect_hiz_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (op[5] || op[6]) |-> dq_oe == 16'h0000);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_pin_n)
    dq_oe == 16'h0000 |-> dq_out == 16'h0000);
endmodule

bind pflash_bus_front pflash_bus_front_chk u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .word_sel(word_sel), .cmd_wr(cmd_wr),
  .cmd_data(cmd_data), .dq_oe(dq_oe), .dq_out(dq_out), .op(op), .rd_mode(rd_mode)
);

// File: tb/test_pflash_bus_front.sv
`timescale 1ns/1ps
module test_pflash_bus_front;
  localparam int AW = 7;
  logic clk = 1'b0;
  logic ce_n = 1, oe_n = 1, we_n = 1, rst_pin_n = 0, rst_hv = 0, word_sel = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = 16'h00F0;
  logic [15:0] dq_out, dq_oe, cmd_data;
  logic [7:0] op;
  logic cmd_wr;
  logic [AW:0] cmd_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pflash_bus_front #(.ADDR_W(AW), .MEM_WORDS(16)) i_pflash_bus_front (
    .clk(clk), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rst_pin_n(rst_pin_n),
    .rst_hv(rst_hv), .word_sel(word_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .op(op), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  function automatic logic [15:0] arr(input int i);
    return 16'(i * 257) ^ 16'h5AC3;
  endfunction

  function automatic logic [7:0] exp_op(input logic hv, ce, oe, we, a6, a1, a0);
    if (hv) begin
      if (!ce && oe && !we && a1 && !a0) return a6 ? 8'h40 : 8'h20;
      return 8'h80;
    end
    if (ce) return 8'h04;
    if (!oe && we) return 8'h01;
    if (oe && !we) return 8'h02;
    return 8'h08;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ctl(input logic c, o, w);
    ce_n = c; oe_n = o; we_n = w;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [AW:0] ea, input logic [15:0] ed);
    addr = a; dq_in = d; ctl(0, 1, 0); tick();
    chk("R6 no strobe while low", cmd_wr, 0);
    we_n = 1; tick();
    chk("R6 strobe on rise", cmd_wr, 1);
    chk("R6 cmd_addr", cmd_addr, ea);
    chk("R6 cmd_data", cmd_data, ed);
    tick();
    chk("R6 single pulse", cmd_wr, 0);
    ce_n = 1; tick();
  endtask

  task automatic read_word(input logic [AW-1:0] a, input logic [15:0] e, input string tag);
    word_sel = 1; addr = a; ctl(0, 0, 1); tick();
    chk(tag, dq_out, e);
    ce_n = 1;
  endtask

  initial begin
    tick(); tick();
    chk("R1 reset op", op, 8'h10);
    chk("R1 reset hiz", dq_oe, 0);
    ctl(0, 0, 1); tick();
    chk("R1 reset overrides read", dq_oe, 0);
    ctl(1, 1, 1); rst_pin_n = 1; tick();
    chk("R2 standby op", op, 8'h04);
    chk("R2 standby hiz", dq_oe, 0);

    // R1 R2 R5 R8 R9: control sweep
    for (int hv = 0; hv < 2; hv++)
      for (int c = 0; c < 8; c++)
        for (int ab = 0; ab < 8; ab++) begin
          logic ce, oe, we, a6, a1, a0, drv;
          {ce, oe, we} = 3'(c); {a6, a1, a0} = 3'(ab);
          rst_hv = 1'(hv); ctl(ce, oe, we);
          addr = '0; addr[6] = a6; addr[1] = a1; addr[0] = a0;
          dq_in = 16'h00F0; word_sel = 1;
          tick();
          drv = !ce && !oe && we;
          chk("R1 R5 R8 R9 op decode", op, exp_op(1'(hv), ce, oe, we, a6, a1, a0));
          chk("R3 R5 R8 R9 enables", dq_oe, drv ? 16'hFFFF : 16'h0000);
          chk("R3 R9 R10 data", dq_out, drv ? arr({a1, a0}) : 16'h0000);
        end
    rst_hv = 0; ctl(1, 1, 1); tick();

    // R3 word reads
    for (int i = 0; i < 16; i++) begin
      addr = {3'(i * 3), 4'(i)}; ctl(0, 0, 1); tick();
      chk("R3 word read", dq_out, arr(i));
      chk("R3 read op", op, 8'h01);
    end
    // R4 byte reads
    word_sel = 0;
    for (int i = 0; i < 16; i++)
      for (int h = 0; h < 2; h++) begin
        addr = 7'(i); dq_in = 16'h0000; dq_in[15] = 1'(h); tick();
        chk("R4 byte enables", dq_oe, 16'h00FF);
        chk("R4 byte data", dq_out, {8'h00, h ? arr(i)[15:8] : arr(i)[7:0]});
      end
    word_sel = 1; ctl(1, 1, 1); tick();

    // R10 latency
    addr = 7'd3; ctl(0, 0, 1); tick();
    addr = 7'd9; #1;
    chk("R10 no change before edge", dq_out, arr(3));
    tick();
    chk("R10 change after edge", dq_out, arr(9));
    ctl(1, 1, 1); tick();

    // R6 R7 writes
    do_write(7'd5, 16'h1234, 8'd10, 16'h1234);
    read_word(7'd2, 16'h1234, "R7 read returns command");
    word_sel = 0; addr = 7'd2; dq_in = 16'h8000; ctl(0, 0, 1); tick();
    chk("R7 R4 high half of command", dq_out, 16'h0012);
    ctl(1, 1, 1); tick();
    word_sel = 0;
    do_write(7'd6, 16'h80F0, 8'd13, 16'h00F0);
    read_word(7'd7, arr(7), "R7 F0 returns to array");

    // R6 blocked strobes
    dq_in = 16'h0033; ctl(0, 0, 0); tick();
    chk("R5 oe and we low", op, 8'h08);
    we_n = 1; tick();
    chk("R6 no strobe with oe low", cmd_wr, 0);
    ctl(1, 1, 0); tick(); we_n = 1; tick();
    chk("R6 no strobe with ce high", cmd_wr, 0);
    read_word(7'd4, arr(4), "R6 blocked writes keep array mode");

    // R9 writes under flag
    rst_hv = 1; word_sel = 1;
    do_write(7'd1, 16'h0055, 8'd2, 16'h0055);
    addr = 7'd1; ctl(0, 0, 1); tick();
    chk("R9 temp op", op, 8'h80);
    chk("R9 read command under flag", dq_out, 16'h0055);
    ce_n = 1; rst_hv = 0; tick();

    // R11 reset restores array mode
    rst_pin_n = 0; #1;
    chk("R1 async reset op", op, 8'h10);
    tick(); rst_pin_n = 1; tick();
    read_word(7'd11, arr(11), "R11 array after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule